// File: doc/BRIEF.md
# Arbitrated Two-Port Mailbox Memory

This block is a small shared memory through which two processors exchange words. Each of its two ports has its own address, write data, read data and three active-low strobes: select, write and output enable. The block samples the strobes on every rising clock edge. The ports normally work on their own schedules. One port can write while the other reads, and the two can use different addresses in the same cycle.

When both ports select the same word, a first-come arbiter decides which port may access it. The port that already held that address keeps its access. The other port's access is cancelled, and the block reports this by pulling that port's not-ready flag low. If both ports arrive at the same address in the same cycle, a fixed tie-break picks the winner. The read data is registered. A separate read-valid output stands in for a tri-state bus and tells the consumer when the data lines carry a word.

Top module: `mbox_dpram`

## Requirements
- R1: With select low and write low at a clock edge, the input word is stored at the addressed location, whatever the output-enable level is, and no read data is presented after that edge.
- R2: With select low, write high and output enable low, the port's read-valid is high after that edge and the read data equals the stored word at the address.
- R3: With select high, the port neither stores nor reads, even if its write strobe is low, and its read-valid is low after that edge.
- R4: With select low and both write and output enable high, nothing is stored and read-valid is low after that edge.
- R5: The two ports complete their accesses in the same cycle when their addresses differ, and neither port disturbs the other's data.
- R6: When both ports select one address and one of them already selected it at the previous edge, that earlier port keeps access and the other port's not-ready flag is low after the edge.
- R7: A port whose access is refused stores nothing, and its read-valid stays low after that edge.
- R8: When the two ports do not select the same address, both not-ready flags are high after the edge.
- R9: When both ports first select the same address at one edge, port A wins by default (parameter TIE_B_WINS = 0).
- R10: The losing port's not-ready flag returns high after the first edge at which the winner has deselected or moved away. The losing port's access takes effect at that same edge.
- R11: After reset, both read-valid outputs are low, both not-ready flags are high and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid (tri-state enable) |
| a_rdy_n | output | 1 | Port A not-ready flag, low when refused |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid (tri-state enable) |
| b_rdy_n | output | 1 | Port B not-ready flag, low when refused |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 8-bit words and the port-A tie-break. These defaults cover the full 256-word map and make the simultaneous-arrival case decide in favour of port A, so the bench can predict that winner. With them, each kind of contention can be driven directly on the ports: A arriving first, B arriving first, both arriving together, and the release after the winner leaves. Refused writes are then detected by reading the contested address back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_QUIET = 2'd3
   } mbox_op_e;

   localparam int unsigned NPORTS = 2;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_pkg::*;
(
   input  logic     sel_n,
   input  logic     wr_n,
   input  logic     oe_n,
   output mbox_op_e op,
   output logic     active
);

   always_comb begin
      if (sel_n)      op = OP_NONE;
      else if (!wr_n) op = OP_WRITE;
      else if (!oe_n) op = OP_READ;
      else            op = OP_QUIET;
   end

   assign active = !sel_n;

endmodule

// File: rtl/mbox_arbiter.sv
module mbox_arbiter #(
   parameter int unsigned ADDR_W     = 8,
   parameter bit          TIE_B_WINS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_a,
   input  logic              act_b,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              blk_a,
   output logic              blk_b
);

   logic              act_a_q, act_b_q;
   logic [ADDR_W-1:0] addr_a_q, addr_b_q;
   logic              owner_b_q;
   logic              held_a, held_b, collide, win_b, tie_b;

   generate
      if (TIE_B_WINS) begin : g_tie_b
         assign tie_b = 1'b1;
      end else begin : g_tie_a
         assign tie_b = 1'b0;
      end
   endgenerate

   assign held_a  = act_a && act_a_q && (addr_a_q == addr_a);
   assign held_b  = act_b && act_b_q && (addr_b_q == addr_b);
   assign collide = act_a && act_b && (addr_a == addr_b);

   always_comb begin
      if (held_a && !held_b)      win_b = 1'b0;
      else if (held_b && !held_a) win_b = 1'b1;
      else if (held_a && held_b)  win_b = owner_b_q;
      else                        win_b = tie_b;
   end

   assign blk_a = collide && win_b;
   assign blk_b = collide && !win_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_a_q   <= 1'b0;
         act_b_q   <= 1'b0;
         addr_a_q  <= '0;
         addr_b_q  <= '0;
         owner_b_q <= 1'b0;
      end else begin
         act_a_q  <= act_a;
         act_b_q  <= act_b;
         addr_a_q <= addr_a;
         addr_b_q <= addr_b;
         if (collide) owner_b_q <= win_b;
      end
   end

   // R6: a collision never refuses both ports
   assert_single_refusal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_a && blk_b));

   // R6: a port that kept an address alone keeps it against a newcomer
   assert_holder_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (collide && held_a && !held_b) |-> !blk_a);

endmodule

// File: rtl/mbox_store.sv
module mbox_store
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we    [NPORTS],
   input  logic              re    [NPORTS],
   input  logic [ADDR_W-1:0] addr  [NPORTS],
   input  logic [DATA_W-1:0] wdata [NPORTS],
   output logic [DATA_W-1:0] rdata [NPORTS],
   output logic              rval  [NPORTS]
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int p = 0; p < NPORTS; p++) begin
         if (we[p]) mem[addr[p]] <= wdata[p];
      end
   end

   genvar gp;
   generate
      for (gp = 0; gp < NPORTS; gp++) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata[gp] <= '0;
               rval[gp]  <= 1'b0;
            end else if (re[gp]) begin
               rdata[gp] <= mem[addr[gp]];
               rval[gp]  <= 1'b1;
            end else begin
               rdata[gp] <= '0;
               rval[gp]  <= 1'b0;
            end
         end
      end
   endgenerate

   // R5: two granted writers never share one word
   assert_no_double_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(we[0] && we[1] && (addr[0] == addr[1])));

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter bit          TIE_B_WINS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel_n,
   input  logic              a_wr_n,
   input  logic              a_oe_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_rvalid,
   output logic              a_rdy_n,
   input  logic              b_sel_n,
   input  logic              b_wr_n,
   input  logic              b_oe_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_rvalid,
   output logic              b_rdy_n
);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("mbox_dpram: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mbox_dpram: DATA_W must be at least 1");
      end
   endgenerate

   logic              sel_n_v [NPORTS];
   logic              wr_n_v  [NPORTS];
   logic              oe_n_v  [NPORTS];
   logic [ADDR_W-1:0] addr_v  [NPORTS];
   logic [DATA_W-1:0] wdata_v [NPORTS];
   mbox_op_e          op_v    [NPORTS];
   logic              act_v   [NPORTS];
   logic              blk_v   [NPORTS];
   logic              we_v    [NPORTS];
   logic              re_v    [NPORTS];
   logic [DATA_W-1:0] rdata_v [NPORTS];
   logic              rval_v  [NPORTS];
   logic              rdy_n_q [NPORTS];

   assign sel_n_v[0] = a_sel_n;  assign sel_n_v[1] = b_sel_n;
   assign wr_n_v[0]  = a_wr_n;   assign wr_n_v[1]  = b_wr_n;
   assign oe_n_v[0]  = a_oe_n;   assign oe_n_v[1]  = b_oe_n;
   assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
   assign wdata_v[0] = a_wdata;  assign wdata_v[1] = b_wdata;

   genvar gp;
   generate
      for (gp = 0; gp < NPORTS; gp++) begin : g_port
         mbox_port_decode i_dec (
            .sel_n  (sel_n_v[gp]),
            .wr_n   (wr_n_v[gp]),
            .oe_n   (oe_n_v[gp]),
            .op     (op_v[gp]),
            .active (act_v[gp])
         );

         assign we_v[gp] = (op_v[gp] == OP_WRITE) && !blk_v[gp];
         assign re_v[gp] = (op_v[gp] == OP_READ)  && !blk_v[gp];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdy_n_q[gp] <= 1'b1;
            else        rdy_n_q[gp] <= !blk_v[gp];
         end

         // R3: a deselected port presents no data after the edge
         assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            sel_n_v[gp] |=> !rval_v[gp]);

         // R4: selected with both strobes high presents no data
         assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n_v[gp] && wr_n_v[gp] && oe_n_v[gp]) |=> !rval_v[gp]);

         // R2: valid data only follows a sampled read request
         assert_read_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rval_v[gp]) |-> $past(!sel_n_v[gp] && wr_n_v[gp] && !oe_n_v[gp]));

         // R7: a refused port shows no read data
         assert_refused_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !rdy_n_q[gp] |-> !rval_v[gp]);
      end
   endgenerate

   mbox_arbiter #(
      .ADDR_W     (ADDR_W),
      .TIE_B_WINS (TIE_B_WINS)
   ) i_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_a  (act_v[0]),
      .act_b  (act_v[1]),
      .addr_a (addr_v[0]),
      .addr_b (addr_v[1]),
      .blk_a  (blk_v[0]),
      .blk_b  (blk_v[1])
   );

   mbox_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_v),
      .re    (re_v),
      .addr  (addr_v),
      .wdata (wdata_v),
      .rdata (rdata_v),
      .rval  (rval_v)
   );

   assign a_rdata  = rdata_v[0];
   assign a_rvalid = rval_v[0];
   assign a_rdy_n  = rdy_n_q[0];
   assign b_rdata  = rdata_v[1];
   assign b_rvalid = rval_v[1];
   assign b_rdy_n  = rdy_n_q[1];

   // R8: without a shared address both flags are high after the edge
   assert_calm_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!a_sel_n && !b_sel_n && (a_addr == b_addr)) |=> (a_rdy_n && b_rdy_n));

   // R6: at most one port is refused at a time
   assert_one_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!a_rdy_n && !b_rdy_n));

endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       a_sel_n = 1'b1, a_wr_n = 1'b1, a_oe_n = 1'b1;
   logic [7:0] a_addr = '0, a_wdata = '0;
   logic       b_sel_n = 1'b1, b_wr_n = 1'b1, b_oe_n = 1'b1;
   logic [7:0] b_addr = '0, b_wdata = '0;
   logic [7:0] a_rdata, b_rdata;
   logic       a_rvalid, b_rvalid, a_rdy_n, b_rdy_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mbox_dpram i_mbox_dpram (
      .clk (clk), .rst_n (rst_n),
      .a_sel_n (a_sel_n), .a_wr_n (a_wr_n), .a_oe_n (a_oe_n),
      .a_addr (a_addr), .a_wdata (a_wdata),
      .a_rdata (a_rdata), .a_rvalid (a_rvalid), .a_rdy_n (a_rdy_n),
      .b_sel_n (b_sel_n), .b_wr_n (b_wr_n), .b_oe_n (b_oe_n),
      .b_addr (b_addr), .b_wdata (b_wdata),
      .b_rdata (b_rdata), .b_rvalid (b_rvalid), .b_rdy_n (b_rdy_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance one edge; outputs are sampled at the following falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic a_set(input logic s, input logic w, input logic o,
                        input logic [7:0] ad, input logic [7:0] d);
      a_sel_n = s; a_wr_n = w; a_oe_n = o; a_addr = ad; a_wdata = d;
   endtask

   task automatic b_set(input logic s, input logic w, input logic o,
                        input logic [7:0] ad, input logic [7:0] d);
      b_sel_n = s; b_wr_n = w; b_oe_n = o; b_addr = ad; b_wdata = d;
   endtask

   task automatic idle_both();
      a_set(1, 1, 1, 8'h00, 8'h00);
      b_set(1, 1, 1, 8'h00, 8'h00);
      step();
   endtask

   task automatic t_reset();
      chk("R11 a_rvalid", a_rvalid, 0);
      chk("R11 b_rvalid", b_rvalid, 0);
      chk("R11 a_rdy_n", a_rdy_n, 1);
      chk("R11 b_rdy_n", b_rdy_n, 1);
      chk("R11 a_rdata", a_rdata, 0);
      chk("R11 b_rdata", b_rdata, 0);
   endtask

   task automatic t_write_read();
      a_set(0, 0, 0, 8'h10, 8'h5A);   // write with output enable low
      step();
      chk("R1 no data during write", a_rvalid, 0);
      a_set(0, 1, 0, 8'h10, 8'h00);
      step();
      chk("R2 rvalid", a_rvalid, 1);
      chk("R1 R2 read data", a_rdata, 8'h5A);
      idle_both();
   endtask

   task automatic t_independent();
      a_set(0, 0, 1, 8'h20, 8'h11);
      b_set(0, 0, 1, 8'h21, 8'h22);
      step();
      chk("R8 a flag", a_rdy_n, 1);
      chk("R8 b flag", b_rdy_n, 1);
      a_set(0, 1, 0, 8'h21, 8'h00);
      b_set(0, 1, 0, 8'h20, 8'h00);
      step();
      chk("R5 a reads b word", a_rdata, 8'h22);
      chk("R5 b reads a word", b_rdata, 8'h11);
      chk("R5 b rvalid", b_rvalid, 1);
      idle_both();
   endtask

   task automatic t_deselect();
      a_set(1, 0, 0, 8'h20, 8'hFF);
      step();
      chk("R3 rvalid low", a_rvalid, 0);
      a_set(0, 1, 0, 8'h20, 8'h00);
      step();
      chk("R3 word unchanged", a_rdata, 8'h11);
      idle_both();
   endtask

   task automatic t_quiet();
      b_set(0, 1, 1, 8'h21, 8'h77);
      step();
      chk("R4 rvalid low", b_rvalid, 0);
      b_set(0, 1, 0, 8'h21, 8'h00);
      step();
      chk("R4 word unchanged", b_rdata, 8'h22);
      idle_both();
   endtask

   task automatic t_a_first();
      a_set(0, 0, 1, 8'h30, 8'h33);
      step();
      a_set(0, 1, 0, 8'h30, 8'h00);   // A holds the address
      step();
      b_set(0, 0, 1, 8'h30, 8'hEE);   // B arrives late with a write
      step();
      chk("R6 b refused", b_rdy_n, 0);
      chk("R6 a granted", a_rdy_n, 1);
      chk("R6 a read data", a_rdata, 8'h33);
      a_set(1, 1, 1, 8'h00, 8'h00);   // winner leaves
      step();
      chk("R10 b flag back high", b_rdy_n, 1);
      b_set(1, 1, 1, 8'h00, 8'h00);
      a_set(0, 1, 0, 8'h30, 8'h00);
      step();
      chk("R10 late write landed", a_rdata, 8'hEE);
      idle_both();
   endtask

   task automatic t_b_first();
      b_set(0, 0, 1, 8'h40, 8'h44);
      step();
      b_set(0, 1, 0, 8'h40, 8'h00);
      step();
      a_set(0, 0, 1, 8'h40, 8'h99);   // A late write, refused
      step();
      chk("R6 a refused", a_rdy_n, 0);
      chk("R6 b read data", b_rdata, 8'h44);
      a_set(0, 1, 0, 8'h40, 8'h00);   // A late read, refused
      step();
      chk("R7 refused read silent", a_rvalid, 0);
      idle_both();
      b_set(0, 1, 0, 8'h40, 8'h00);
      step();
      chk("R7 refused write dropped", b_rdata, 8'h44);
      idle_both();
   endtask

   task automatic t_tie();
      a_set(0, 0, 1, 8'h50, 8'h55);
      b_set(0, 0, 1, 8'h50, 8'h66);
      step();
      chk("R9 a wins", a_rdy_n, 1);
      chk("R9 b refused", b_rdy_n, 0);
      idle_both();
      a_set(0, 1, 0, 8'h50, 8'h00);
      step();
      chk("R9 a word stored", a_rdata, 8'h55);
      idle_both();
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_write_read();
      t_independent();
      t_deselect();
      t_quiet();
      t_a_first();
      t_b_first();
      t_tie();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule